// File: doc/BRIEF.md
# Control/Bulk List Service Scheduler

This block chooses, for every frame of a host controller, which list of endpoint descriptors is served next. When a frame starts, the periodic list is served first if it was enabled at that frame start. The periodic list ends when the descriptor walker reports that it is exhausted. It also ends early when an isochronous descriptor turns up while isochronous processing is switched off. The rest of the frame is split between the control and bulk lists by a two-bit ratio setting. A persistent counter of non-empty control descriptors decides when bulk gets its turn.

The descriptor walker is outside this block. It reports each handled descriptor with a one-cycle step strobe, qualified by an isochronous flag and an empty flag. It reports the end of the currently selected list with a separate strobe. The selection output is sampled by that walker. The control and bulk enables are captured at each start-of-frame pulse, so writes during a frame do not disturb the frame in progress.

Top module: `list_service_sched`

## Requirements
- R1: After reset the selection `svc_sel` is 3'b000 and stays 3'b000, whatever the step and list-end strobes do, until the first `sof_pulse`.
- R2: Enables are captured only at `sof_pulse`. The cycle after a pulse, `svc_sel` is 3'b001 (bit 0 = periodic) if `per_en` was high at the pulse. Periodic is never selected at any other time. Changing `ctrl_en` or `bulk_en` mid-frame has no effect until the next pulse.
- R3: While periodic is selected, a step with `ed_iso` low, or with `ed_iso` high and `iso_en` high, keeps periodic selected. A `list_end` moves the selection to the control/bulk phase in the next cycle.
- R4: A step with `ed_iso` high while `iso_en` is low and periodic is selected ends periodic service for the frame from the next cycle.
- R5: With both control (bit 1, 3'b010) and bulk (bit 2, 3'b100) available, ratio setting N (0..3) gives N+1 non-empty control descriptors, then one bulk descriptor. A served bulk descriptor resets the control count to zero.
- R6: A control step with `ed_empty` high does not advance the control count, and control stays selected.
- R7: The control count is not cleared by `sof_pulse`.
- R8: If one of control or bulk is disabled (at the last pulse) or exhausted (`list_end` while selected), the other is served regardless of the ratio.
- R9: If neither control nor bulk is available in the control/bulk phase, `svc_sel` is 3'b000 until the next `sof_pulse`.
- R10: At most one bit of `svc_sel` is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_pulse | input | 1 | One-cycle start-of-frame strobe |
| per_en | input | 1 | Periodic list enable |
| iso_en | input | 1 | Isochronous descriptor enable, checked when such a descriptor is reached |
| ctrl_en | input | 1 | Control list enable |
| bulk_en | input | 1 | Bulk list enable |
| ctrl_ratio | input | 2 | Control-to-bulk ratio minus one |
| ed_step | input | 1 | Descriptor handled on the selected list |
| ed_iso | input | 1 | Handled descriptor is isochronous |
| ed_empty | input | 1 | Handled descriptor had no work queued |
| list_end | input | 1 | Selected list is exhausted for this frame |
| svc_sel | output | 3 | One-hot selection: bit0 periodic, bit1 control, bit2 bulk |

## Verification
The hardest situation to reach is a control count that crosses a frame start partway through its ratio cycle. Bulk must then come first in the new frame. The stimulus advances the count with non-empty control steps up to the switch point and pulses start-of-frame with periodic disabled. It then checks that bulk, not control, is selected. Mid-frame enable changes are exercised by clearing the control enable after a frame has started, then checking that control stays selected until the next pulse.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PER  = 2'd1,
    PH_NP   = 2'd2
  } phase_t;

  localparam int SEL_PER  = 0;
  localparam int SEL_CTRL = 1;
  localparam int SEL_BULK = 2;
  localparam int SEL_W    = 3;
endpackage

// File: rtl/lss_rst_sync.sv
module lss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lss_frame_latch.sv
module lss_frame_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [N-1:0] live_en,
  output logic [N-1:0] frame_en
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (capture) q <= live_en[i];
    end
    assign frame_en[i] = q;
  end
endmodule

// File: rtl/lss_ratio_arb.sv
module lss_ratio_arb #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ctrl_ok,
  input  logic               bulk_ok,
  input  logic               ctrl_served,
  input  logic               bulk_served,
  output logic               pick_ctrl,
  output logic               pick_bulk
);
  localparam int CNT_W = RATIO_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = bulk_served | ctrl_served;
    cnt_d  = cnt_q;
    if (bulk_served)                    cnt_d = '0;
    else if (ctrl_served && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    pick_ctrl = ctrl_ok && (!bulk_ok || (cnt_q <= {1'b0, ratio}));
    pick_bulk = bulk_ok && !pick_ctrl;
  end
endmodule

// File: rtl/list_service_sched.sv
module list_service_sched
  import lss_pkg::*;
#(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof_pulse,
  input  logic               per_en,
  input  logic               iso_en,
  input  logic               ctrl_en,
  input  logic               bulk_en,
  input  logic [RATIO_W-1:0] ctrl_ratio,
  input  logic               ed_step,
  input  logic               ed_iso,
  input  logic               ed_empty,
  input  logic               list_end,
  output logic [2:0]         svc_sel
);
  logic       rst_s_n;
  logic [1:0] frame_en;
  phase_t     phase_q, phase_d;
  logic       ctrl_exh_q, ctrl_exh_d, bulk_exh_q, bulk_exh_d;
  logic       pick_ctrl, pick_bulk;
  logic       ctrl_served, bulk_served;
  logic [SEL_W-1:0] sel;

  lss_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s_n)
  );

  lss_frame_latch #(.N(2)) u_latch (
    .clk(clk), .rst_n(rst_s_n), .capture(sof_pulse),
    .live_en({bulk_en, ctrl_en}), .frame_en(frame_en)
  );

  assign ctrl_served = ed_step && sel[SEL_CTRL] && !ed_empty;
  assign bulk_served = ed_step && sel[SEL_BULK];

  lss_ratio_arb #(.RATIO_W(RATIO_W)) u_arb (
    .clk(clk), .rst_n(rst_s_n), .ratio(ctrl_ratio),
    .ctrl_ok(frame_en[0] && !ctrl_exh_q),
    .bulk_ok(frame_en[1] && !bulk_exh_q),
    .ctrl_served(ctrl_served), .bulk_served(bulk_served),
    .pick_ctrl(pick_ctrl), .pick_bulk(pick_bulk)
  );

  always_comb begin
    sel = '0;
    case (phase_q)
      PH_PER:  sel[SEL_PER] = 1'b1;
      PH_NP: begin
        sel[SEL_CTRL] = pick_ctrl;
        sel[SEL_BULK] = pick_bulk;
      end
      default: sel = '0;
    endcase
  end

  always_comb begin
    phase_d    = phase_q;
    ctrl_exh_d = ctrl_exh_q;
    bulk_exh_d = bulk_exh_q;
    if (sof_pulse) begin
      phase_d    = per_en ? PH_PER : PH_NP;
      ctrl_exh_d = 1'b0;
      bulk_exh_d = 1'b0;
    end else if (phase_q == PH_PER) begin
      if (list_end || (ed_step && ed_iso && !iso_en)) phase_d = PH_NP;
    end else if (phase_q == PH_NP && list_end) begin
      if (sel[SEL_CTRL]) ctrl_exh_d = 1'b1;
      if (sel[SEL_BULK]) bulk_exh_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      phase_q    <= PH_IDLE;
      ctrl_exh_q <= 1'b0;
      bulk_exh_q <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      ctrl_exh_q <= ctrl_exh_d;
      bulk_exh_q <= bulk_exh_d;
    end
  end

  assign svc_sel = sel;
endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
  parameter int RATIO_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sof_pulse,
  input logic               iso_en,
  input logic [RATIO_W-1:0] ctrl_ratio,
  input logic               ed_step,
  input logic               ed_iso,
  input logic               ed_empty,
  input logic               list_end,
  input logic [2:0]         svc_sel
);
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_sel));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_sel == 3'b000 && !sof_pulse) |=> (svc_sel == 3'b000));

  p_per_only_at_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_pulse && !svc_sel[0]) |=> !svc_sel[0]);

  p_iso_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_sel[0] && ed_step && ed_iso && !iso_en && !sof_pulse) |=> !svc_sel[0]);

  p_per_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_sel[0] && list_end && !sof_pulse) |=> !svc_sel[0]);

  p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_sel[1] && ed_step && ed_empty && !list_end && !sof_pulse)
      |=> (svc_sel[1] || !$stable(ctrl_ratio)));
endmodule

bind list_service_sched lss_checker #(.RATIO_W(RATIO_W)) u_lss_checker (
  .clk(clk), .rst_n(rst_n), .sof_pulse(sof_pulse), .iso_en(iso_en),
  .ctrl_ratio(ctrl_ratio), .ed_step(ed_step), .ed_iso(ed_iso),
  .ed_empty(ed_empty), .list_end(list_end), .svc_sel(svc_sel)
);

// File: tb/list_service_sched_test.sv
module list_service_sched_test;
  logic       clk, rst_n;
  logic       sof_pulse, per_en, iso_en, ctrl_en, bulk_en;
  logic [1:0] ctrl_ratio;
  logic       ed_step, ed_iso, ed_empty, list_end;
  logic [2:0] svc_sel;
  int         total, bad;
  bit         done;

  localparam logic [2:0] S_NONE = 3'b000, S_PER = 3'b001,
                         S_CTRL = 3'b010, S_BULK = 3'b100;

  list_service_sched uut (
    .clk(clk), .rst_n(rst_n), .sof_pulse(sof_pulse), .per_en(per_en),
    .iso_en(iso_en), .ctrl_en(ctrl_en), .bulk_en(bulk_en),
    .ctrl_ratio(ctrl_ratio), .ed_step(ed_step), .ed_iso(ed_iso),
    .ed_empty(ed_empty), .list_end(list_end), .svc_sel(svc_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [2:0] exp);
    total++;
    if (svc_sel !== exp) begin
      bad++;
      $display("FAIL %s: svc_sel=%b expected=%b", req, svc_sel, exp);
    end
  endtask

  // drive one cycle of strobes at a falling edge, sample at the next one
  task automatic cyc(input logic sof, input logic stp, input logic iso,
                     input logic emp, input logic lend);
    sof_pulse = sof; ed_step = stp; ed_iso = iso; ed_empty = emp; list_end = lend;
    @(posedge clk);
    @(negedge clk);
    sof_pulse = 0; ed_step = 0; ed_iso = 0; ed_empty = 0; list_end = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; sof_pulse = 0; ed_step = 0; ed_iso = 0; ed_empty = 0; list_end = 0;
    per_en = 0; iso_en = 0; ctrl_en = 0; bulk_en = 0; ctrl_ratio = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 after reset", S_NONE);
    per_en = 1; ctrl_en = 1; bulk_en = 1;
    cyc(0, 1, 0, 0, 0); check("R1 step before sof", S_NONE);
    cyc(0, 0, 0, 0, 1); check("R1 list_end before sof", S_NONE);
  endtask

  task automatic t_periodic();
    do_reset();
    per_en = 1; iso_en = 1; ctrl_en = 1; bulk_en = 1;
    cyc(1, 0, 0, 0, 0); check("R2 periodic at sof", S_PER);
    cyc(0, 1, 0, 0, 0); check("R3 plain step keeps periodic", S_PER);
    cyc(0, 1, 1, 0, 0); check("R3 iso enabled keeps periodic", S_PER);
    cyc(0, 0, 0, 0, 1); check("R3 list_end to control", S_CTRL);
  endtask

  task automatic t_iso();
    do_reset();
    per_en = 1; iso_en = 0; ctrl_en = 1; bulk_en = 1;
    cyc(1, 0, 0, 0, 0); check("R4 periodic first", S_PER);
    cyc(0, 1, 0, 0, 0); check("R4 non-iso step stays", S_PER);
    cyc(0, 1, 1, 0, 0); check("R4 iso disabled leaves periodic", S_CTRL);
  endtask

  task automatic t_ratio();
    do_reset();
    ctrl_en = 1; bulk_en = 1; ctrl_ratio = 2'd2;
    cyc(1, 0, 0, 0, 0); check("R5 ratio2 first control", S_CTRL);
    cyc(0, 1, 0, 0, 0); check("R5 ratio2 second control", S_CTRL);
    cyc(0, 1, 0, 0, 0); check("R5 ratio2 third control", S_CTRL);
    cyc(0, 1, 0, 0, 0); check("R5 ratio2 switch to bulk", S_BULK);
    cyc(0, 1, 0, 0, 0); check("R5 bulk resets count", S_CTRL);
    ctrl_ratio = 2'd0;
    cyc(0, 1, 0, 0, 0); check("R5 ratio0 bulk after one", S_BULK);
    cyc(0, 1, 0, 0, 0); check("R5 ratio0 back to control", S_CTRL);
  endtask

  task automatic t_empty();
    do_reset();
    ctrl_en = 1; bulk_en = 1; ctrl_ratio = 2'd0;
    cyc(1, 0, 0, 0, 0); check("R6 control first", S_CTRL);
    cyc(0, 1, 0, 1, 0); check("R6 empty keeps control", S_CTRL);
    cyc(0, 1, 0, 1, 0); check("R6 second empty keeps control", S_CTRL);
    cyc(0, 1, 0, 0, 0); check("R6 non-empty then bulk", S_BULK);
  endtask

  task automatic t_persist();
    do_reset();
    ctrl_en = 1; bulk_en = 1; ctrl_ratio = 2'd1;
    cyc(1, 0, 0, 0, 0); check("R7 control first", S_CTRL);
    cyc(0, 1, 0, 0, 0); check("R7 control second", S_CTRL);
    cyc(0, 1, 0, 0, 0); check("R7 bulk due", S_BULK);
    cyc(1, 0, 0, 0, 0); check("R7 count survives sof", S_BULK);
  endtask

  task automatic t_shadow();
    do_reset();
    ctrl_en = 1; bulk_en = 1;
    cyc(1, 0, 0, 0, 0); check("R2 control at sof", S_CTRL);
    ctrl_en = 0; per_en = 1;
    cyc(0, 1, 0, 1, 0); check("R2 mid-frame writes ignored", S_CTRL);
    cyc(1, 0, 0, 0, 0); check("R2 periodic from next frame", S_PER);
    cyc(0, 0, 0, 0, 1); check("R8 control disabled gives bulk", S_BULK);
  endtask

  task automatic t_exhaust();
    do_reset();
    ctrl_en = 1; bulk_en = 1; ctrl_ratio = 2'd3;
    cyc(1, 0, 0, 0, 0); check("R8 control first", S_CTRL);
    cyc(0, 0, 0, 0, 1); check("R8 control exhausted gives bulk", S_BULK);
    cyc(0, 1, 0, 0, 0); check("R8 bulk continues", S_BULK);
    cyc(0, 0, 0, 0, 1); check("R9 both unavailable idle", S_NONE);
    cyc(0, 1, 0, 0, 0); check("R9 idle holds", S_NONE);
    cyc(1, 0, 0, 0, 0); check("R9 sof restarts control", S_CTRL);
    ctrl_en = 0; bulk_en = 0;
    cyc(1, 0, 0, 0, 0); check("R9 nothing enabled idle", S_NONE);
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    t_reset();
    t_periodic();
    t_iso();
    t_ratio();
    t_empty();
    t_persist();
    t_shadow();
    t_exhaust();
    check("R10 selection onehot at end", S_NONE);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule